// File: doc/BRIEF.md
# Configurable Multi-Unit Distributed-Arithmetic FIR Filter

This block computes one output of a 64-tap FIR filter for each accepted input sample, with no multiplier. The taps are split across sixteen lookup units of four taps each. Every unit owns a small table holding all sixteen sums of its four coefficients. For each sample bit, from the sign bit downwards, the unit forms a table address from one bit of each of its four samples, reads the entry, and shifts it into a running total. After the last bit, the sixteen unit totals are added into one signed result, which leaves on a registered output with a one-cycle valid strobe.

Two settings trade accuracy for switching activity, and either may change from one sample to the next. The unit count sets how many four-tap groups take part, so it sets the filter length. The precision setting sets how many sample bits, counted from the sign bit, are clocked through, so it sets both the run time and the quantisation of the input. Tables are loaded by software-free plain writes through one shared port, addressed by unit and entry, while the filter is idle.

Top module: `da_fir_multi`

## Requirements
- R1: After reset `busy`, `out_valid` and `out_data` are all zero, and the sample history holds zeros.
- R2: A sample is accepted in a cycle where `in_valid` is high and `busy` is low. `busy` is high from the next cycle on, and `out_valid` is high for exactly one cycle, P+2 cycles after the accepting edge, with `busy` low in that cycle, where P is the number of bits processed.
- R3: With all units active and full precision, `out_data` equals the sum over taps j = 0..63 of c[j]·x[j], as a 24-bit two's complement value.
- R4: `cfg_prec` selects P = `cfg_prec`+1 bits. Each sample then enters the sum as its value arithmetically shifted right by 8-P.
- R5: Only units with index below `cfg_units` contribute; a value above 16 acts as 16 and 0 yields a result of zero.
- R6: x[0] is the newest accepted sample and x[j] the one accepted j samples earlier. Unit u holds taps 4u..4u+3, and unit-local tap k drives bit k of that unit's table address, so entry a of unit u must hold the sum of c[4u+k] over the set bits k of a.
- R7: The sign-bit step subtracts its table entry, so negative samples, including -128, enter with their two's complement value.
- R8: A sample presented while `busy` is high is dropped and does not enter the history.
- R9: A table write (`tw_en` high) while `busy` is high is dropped and leaves the table unchanged; when `busy` is low it stores `tw_data` (12-bit signed) in entry `tw_entry` of unit `tw_unit`.
- R10: `cfg_units` and `cfg_prec` are captured at acceptance; changes during a run do not affect that run.
- R11: `out_data` holds its value between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offers a new sample |
| in_sample | input | 8 | Signed input sample |
| cfg_units | input | 5 | Number of active four-tap units (0..16, larger saturates) |
| cfg_prec | input | 3 | Number of sample bits processed, minus one |
| tw_en | input | 1 | Table write strobe |
| tw_unit | input | 4 | Unit index of the table write |
| tw_entry | input | 4 | Entry index of the table write |
| tw_data | input | 12 | Signed table entry value |
| busy | output | 1 | A sample is being processed |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_data | output | 24 | Signed filter result |

## Verification
The properties assume that `in_valid` and `cfg_prec` are only meaningful at acceptance, and that the table contents are loaded with coefficient sums small enough that neither a unit total nor the 24-bit result wraps. The bench keeps coefficients within ±200 so each entry fits in 12 bits and the largest output stays far inside 24 bits. It loads every table before the first sample and pokes samples, table writes and settings only in busy cycles when checking that they are ignored, so the run-length property sees the settings captured at acceptance.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_SUM
  } fir_state_e;

endpackage

// File: rtl/da_delay_line.sv
module da_delay_line #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_en,
  input  logic [W-1:0]             din,
  output logic [DEPTH-1:0][W-1:0]  taps
);

  // taps[0] holds the newest sample
  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else if (shift_en) begin
      taps <= {taps[DEPTH-2:0], din};
    end
  end

endmodule

// File: rtl/da_ctrl.sv
module da_ctrl
  import da_fir_pkg::*;
#(
  parameter int PREC_W = 3,
  parameter int UCNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PREC_W-1:0] cfg_prec,
  input  logic [UCNT_W-1:0] cfg_units,
  output logic              accept,
  output logic              load,
  output logic              step,
  output logic              first,
  output logic              finish,
  output logic              busy,
  output logic [UCNT_W-1:0] units_q
);

  fir_state_e        state;
  logic [PREC_W-1:0] prec_q;
  logic [PREC_W-1:0] bit_cnt;

  assign accept = (state == ST_IDLE) && in_valid;
  assign load   = (state == ST_LOAD);
  assign step   = (state == ST_RUN);
  assign first  = (state == ST_RUN) && (bit_cnt == '0);
  assign finish = (state == ST_SUM);
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      prec_q  <= '0;
      units_q <= '0;
      bit_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            prec_q  <= cfg_prec;
            units_q <= cfg_units;
            state   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          bit_cnt <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == prec_q) begin
            state <= ST_SUM;
          end
        end
        ST_SUM: begin
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/da_unit.sv
module da_unit #(
  parameter int TAPS   = 4,
  parameter int SAMP_W = 8,
  parameter int LUT_W  = 12
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               load,
  input  logic                               step,
  input  logic                               first,
  input  logic                               active,
  input  logic [TAPS-1:0][SAMP_W-1:0]        taps_in,
  input  logic                               wr_en,
  input  logic [TAPS-1:0]                    wr_addr,
  input  logic [LUT_W-1:0]                   wr_data,
  output logic signed [LUT_W+SAMP_W-1:0]     acc_out
);

  localparam int DEPTH = 1 << TAPS;
  localparam int ACC_W = LUT_W + SAMP_W;

  logic [LUT_W-1:0]            lut [DEPTH];
  logic [TAPS-1:0][SAMP_W-1:0] sr;
  logic [TAPS-1:0]             rd_addr;
  logic signed [ACC_W-1:0]     term;
  logic signed [ACC_W-1:0]     acc;
  logic signed [ACC_W-1:0]     acc_next;

  // table storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      lut[wr_addr] <= wr_data;
    end
  end

  // one address bit per local tap, taken from the current top bit
  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      rd_addr[k] = sr[k][SAMP_W-1];
    end
  end

  assign term     = ACC_W'($signed(lut[rd_addr]));
  assign acc_next = (acc <<< 1) + (first ? -term : term);

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      acc <= '0;
    end else if (load) begin
      sr  <= active ? taps_in : '0;
      acc <= '0;
    end else if (step && active) begin
      for (int k = 0; k < TAPS; k++) begin
        sr[k] <= {sr[k][SAMP_W-2:0], 1'b0};
      end
      acc <= acc_next;
    end
  end

  assign acc_out = acc;

endmodule

// File: rtl/da_fir_multi.sv
module da_fir_multi #(
  parameter int N_UNITS   = 16,
  parameter int UNIT_TAPS = 4,
  parameter int SAMP_W    = 8,
  parameter int LUT_W     = 12,
  parameter int OUT_W     = 24
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [SAMP_W-1:0]             in_sample,
  input  logic [$clog2(N_UNITS+1)-1:0]  cfg_units,
  input  logic [$clog2(SAMP_W)-1:0]     cfg_prec,
  input  logic                          tw_en,
  input  logic [$clog2(N_UNITS)-1:0]    tw_unit,
  input  logic [UNIT_TAPS-1:0]          tw_entry,
  input  logic [LUT_W-1:0]              tw_data,
  output logic                          busy,
  output logic                          out_valid,
  output logic [OUT_W-1:0]              out_data
);

  localparam int N_TAPS = N_UNITS * UNIT_TAPS;
  localparam int UACC_W = LUT_W + SAMP_W;
  localparam int UCNT_W = $clog2(N_UNITS + 1);
  localparam int PREC_W = $clog2(SAMP_W);
  localparam int UIDX_W = $clog2(N_UNITS);

  logic                            accept;
  logic                            load;
  logic                            step;
  logic                            first;
  logic                            finish;
  logic [UCNT_W-1:0]               units_q;
  logic [N_TAPS-1:0][SAMP_W-1:0]   hist;
  logic [N_UNITS-1:0]              active;
  logic [N_UNITS-1:0]              wr_sel;
  logic signed [UACC_W-1:0]        unit_acc [N_UNITS];
  logic signed [OUT_W-1:0]         sum_c;

  da_ctrl #(
    .PREC_W (PREC_W),
    .UCNT_W (UCNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .cfg_prec  (cfg_prec),
    .cfg_units (cfg_units),
    .accept    (accept),
    .load      (load),
    .step      (step),
    .first     (first),
    .finish    (finish),
    .busy      (busy),
    .units_q   (units_q)
  );

  da_delay_line #(
    .DEPTH (N_TAPS),
    .W     (SAMP_W)
  ) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (accept),
    .din      (in_sample),
    .taps     (hist)
  );

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    assign active[u] = (units_q > UCNT_W'(u));
    assign wr_sel[u] = tw_en && !busy && (tw_unit == UIDX_W'(u));

    da_unit #(
      .TAPS   (UNIT_TAPS),
      .SAMP_W (SAMP_W),
      .LUT_W  (LUT_W)
    ) u_unit (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .step    (step),
      .first   (first),
      .active  (active[u]),
      .taps_in (hist[u*UNIT_TAPS +: UNIT_TAPS]),
      .wr_en   (wr_sel[u]),
      .wr_addr (tw_entry),
      .wr_data (tw_data),
      .acc_out (unit_acc[u])
    );
  end

  always_comb begin
    sum_c = '0;
    for (int u = 0; u < N_UNITS; u++) begin
      if (active[u]) begin
        sum_c = sum_c + OUT_W'(unit_acc[u]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= finish;
      if (finish) begin
        out_data <= sum_c;
      end
    end
  end

endmodule

// File: rtl/da_fir_multi_chk.sv
module da_fir_multi_chk #(
  parameter int SAMP_W = 8,
  parameter int OUT_W  = 24
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic [$clog2(SAMP_W)-1:0] cfg_prec,
  input logic                      busy,
  input logic                      out_valid,
  input logic [OUT_W-1:0]          out_data
);

  localparam int PREC_W = $clog2(SAMP_W);
  localparam int RCNT_W = PREC_W + 2;

  logic [RCNT_W-1:0] run_cnt;
  logic [PREC_W-1:0] prec_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      prec_lat <= '0;
    end else if (in_valid && !busy) begin
      run_cnt  <= RCNT_W'(1);
      prec_lat <= cfg_prec;
    end else if (busy && (run_cnt != '1)) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !busy);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);

  // R4
  run_len_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (run_cnt == RCNT_W'(prec_lat) + RCNT_W'(4)));

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

endmodule

bind da_fir_multi da_fir_multi_chk #(
  .SAMP_W (SAMP_W),
  .OUT_W  (OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .cfg_prec  (cfg_prec),
  .busy      (busy),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_da_fir_multi.sv
`timescale 1ns/1ps
module tb_da_fir_multi;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_sample = '0;
  logic [4:0]  cfg_units = 5'd16;
  logic [2:0]  cfg_prec = 3'd7;
  logic        tw_en = 1'b0;
  logic [3:0]  tw_unit = '0;
  logic [3:0]  tw_entry = '0;
  logic [11:0] tw_data = '0;
  logic        busy;
  logic        out_valid;
  logic [23:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int coef [64];
  int hist [64];

  always #4 clk = ~clk;

  da_fir_multi dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_units(cfg_units), .cfg_prec(cfg_prec), .tw_en(tw_en),
    .tw_unit(tw_unit), .tw_entry(tw_entry), .tw_data(tw_data),
    .busy(busy), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic int model(input int n, input int p);
    int s = 0;
    int nn = (n > 16) ? 16 : n;
    for (int u = 0; u < nn; u++)
      for (int k = 0; k < 4; k++)
        s += coef[4*u+k] * (hist[4*u+k] >>> (8 - p));
    return s;
  endfunction

  task automatic load_tables();
    for (int i = 0; i < 64; i++) coef[i] = ((i * 73 + 19) % 401) - 200;
    for (int u = 0; u < 16; u++) begin
      for (int a = 0; a < 16; a++) begin
        int e = 0;
        for (int k = 0; k < 4; k++) if (a[k]) e += coef[4*u+k];
        @(negedge clk);
        tw_en = 1'b1; tw_unit = u[3:0]; tw_entry = a[3:0]; tw_data = e[11:0];
      end
    end
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  // one sample through the filter; optional pokes during the busy window
  task automatic run(input int x, input int n, input int psel, input bit poke, input string req);
    int p = psel + 1;
    int k = 0;
    int exp;
    int got;
    @(negedge clk);
    check(!busy, "R2 idle before accept", busy, 0);
    in_valid = 1'b1; in_sample = x[7:0]; cfg_units = n[4:0]; cfg_prec = psel[2:0];
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 63; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = $signed(x[7:0]);
    exp = model(n, p);
    check(busy, "R2 busy after accept", busy, 1);
    if (poke) begin
      // R8 R9 R10: dropped sample, dropped write, changed settings
      in_valid = 1'b1; in_sample = 8'h55;
      tw_en = 1'b1; tw_unit = 4'd0; tw_entry = 4'd15; tw_data = 12'h7FF;
      cfg_units = 5'd1; cfg_prec = 3'd0;
    end
    while (!out_valid && k < 40) begin
      @(negedge clk);
      k++;
      if (k == 1) begin in_valid = 1'b0; tw_en = 1'b0; end
    end
    check(k == p + 2, "R2 latency", k, p + 2);
    got = int'($signed(out_data));
    check(got == exp, req, got, exp);
    @(negedge clk);
    check(!out_valid, "R2 single-cycle strobe", out_valid, 0);
  endtask

  task automatic t_reset();
    check(!busy, "R1 busy", busy, 0);
    check(!out_valid, "R1 out_valid", out_valid, 0);
    check(out_data == '0, "R1 out_data", out_data, 0);
  endtask

  task automatic t_map();
    run(1, 16, 7, 0, "R1 R6 impulse at tap 0");
    for (int j = 1; j < 6; j++) run(0, 16, 7, 0, "R6 impulse walk");
  endtask

  task automatic t_full();
    for (int i = 0; i < 64; i++) begin
      int v = ((i * 29 + 5) % 256) - 128;
      if (i == 10) v = -128;
      if (i == 20) v = 127;
      run(v, 16, 7, 0, "R3 R7 full filter");
    end
  endtask

  task automatic t_prec();
    for (int ps = 0; ps < 8; ps++) run(-77 + ps * 30, 16, ps, 0, "R4 precision");
  endtask

  task automatic t_units();
    run(45, 0, 7, 0, "R5 zero units");
    run(-90, 1, 7, 0, "R5 one unit");
    run(113, 5, 7, 0, "R5 five units");
    run(-3, 20, 7, 0, "R5 saturating count");
    run(66, 9, 3, 0, "R4 R5 mixed");
  endtask

  task automatic t_busy_ignore();
    for (int i = 0; i < 3; i++) run(-1, 16, 7, 0, "R7 all-ones");
    run(-1, 16, 7, 1, "R8 R9 R10 pokes while busy");
    run(-1, 16, 7, 0, "R8 R9 history and table intact");
  endtask

  task automatic t_hold();
    logic [23:0] last;
    run(100, 16, 7, 0, "R3 before hold");
    last = out_data;
    repeat (6) @(negedge clk);
    check(out_data == last, "R11 hold", int'(out_data), int'(last));
    check(!out_valid, "R11 no strobe when idle", out_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    load_tables();
    t_reset();
    t_map();
    t_full();
    t_prec();
    t_units();
    t_busy_ignore();
    t_hold();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog got=1 expected=0");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule